// File: doc/BRIEF.md
# Port Line Edge Interrupt Controller

This block watches two chosen lines of each of four 8-bit input ports and turns a selected edge on one of them into a pending interrupt for that port's group. Each group has a byte-wide control register that selects the line, the edge polarity and the group's pending flag. Any number of groups can hold a pending flag at once. A single request line tells the host that at least one enabled group needs service. Software reads the registers to find the pending groups and clears each flag by writing a one to it.

The port lines are asynchronous to the clock. They pass through a two-stage synchroniser before edge detection. Register access is a plain single-cycle write strobe with a combinational read port. There is no handshake and no back-pressure on either side.

Top module: `port_irq_ctrl`

## Requirements
- R1: After reset every control register reads 0x00 and `irq` is low.
- R2: With mode field `01`, line 0 of the group's port is the source. A level change on that line that is first sampled at clock edge k sets the flag at edge k+2. `irq` is high after that edge and not before it.
- R3: With mode field `10`, line 3 of the group's port is the source. Edges on line 0 then have no effect.
- R4: Edge bit 0 selects the rising edge and edge bit 1 selects the falling edge. An edge of the other polarity does not set the flag.
- R5: Mode fields `00` and `11` never set the flag. Lines other than 0 and 3 never set any flag.
- R6: A set flag stays set until software writes its register with bit 3 = 1. Writing bit 3 = 0 leaves the flag unchanged.
- R7: If a source edge and a clear write act on the same group in the same cycle, the flag ends up set.
- R8: `irq` is the OR of the flags of all groups whose mode is `01` or `10`. Changing a group's mode to `00` drops its share of `irq` but keeps its flag. Restoring the mode raises `irq` again.
- R9: Group n's register is at address 16+n. Its fields are: bits [5:4] mode, bit 1 edge, bit 3 flag (reads the flag, write 1 clears it). All other bits read 0. Other addresses read 0x00, and writes to them change nothing.
- R10: Groups work independently. Flags in several groups can be set together, and clearing one leaves the others pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| port_c | input | 32 | Four 8-bit ports; group n uses bits [8n+7:8n] |
| irq | output | 1 | Combined interrupt request |

## Verification
A vector table drives single transitions on the source and non-source lines under each mode and edge setting. Rising versus falling transitions separate the two edge polarities. Toggling line 0 under mode `10`, and line 3 under mode `01`, shows whether the source mux selects the right line. Disabled modes and lines outside the two candidates must leave every flag clear. Directed sequences then cover:
- the exact latency of a flag;
- a clear write landing in the same cycle as an edge;
- masking a group by its mode;
- two groups pending together;
- writes to addresses that hold no register.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;
  // control byte layout
  localparam int unsigned EDGE_BIT = 1;
  localparam int unsigned FLAG_BIT = 3;
  localparam int unsigned MODE_LO  = 4;
  localparam int unsigned MODE_HI  = 5;

  typedef enum logic [1:0] {
    SRC_OFF = 2'b00,
    SRC_LO  = 2'b01,
    SRC_HI  = 2'b10,
    SRC_RSV = 2'b11
  } src_sel_e;
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[0] <= '0;
          else        stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[s] <= '0;
          else        stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pirq_group.sv
module pirq_group
  import port_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cand,      // [0] = low source line, [1] = high source line
  input  logic [1:0] mode,
  input  logic       fall_sel,
  input  logic       clr,
  output logic       flag,
  output logic       hit
);
  logic [1:0] prev;
  logic [1:0] rise_ev;
  logic [1:0] fall_ev;
  logic [1:0] sel_ev;

  // both candidates keep their own history so a mode switch makes no false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= cand;
  end

  assign rise_ev = cand & ~prev;
  assign fall_ev = ~cand & prev;
  assign sel_ev  = fall_sel ? fall_ev : rise_ev;

  always_comb begin
    unique case (src_sel_e'(mode))
      SRC_LO:  hit = sel_ev[0];
      SRC_HI:  hit = sel_ev[1];
      default: hit = 1'b0;
    endcase
  end

  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
  import port_irq_pkg::*;
#(
  parameter int unsigned NUM_GRP = 4,
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned BASE    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [7:0]                 wdata,
  input  logic [NUM_GRP-1:0]         flags,
  output logic [NUM_GRP-1:0][1:0]    mode,
  output logic [NUM_GRP-1:0]         fall_sel,
  output logic [NUM_GRP-1:0]         clr,
  output logic [7:0]                 rdata
);
  logic [NUM_GRP-1:0] addr_hit;

  genvar g;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_reg
      assign addr_hit[g] = (addr == ADDR_W'(BASE + g));
      assign clr[g]      = wr && addr_hit[g] && wdata[FLAG_BIT];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mode[g]     <= SRC_OFF;
          fall_sel[g] <= 1'b0;
        end else if (wr && addr_hit[g]) begin
          mode[g]     <= wdata[MODE_HI:MODE_LO];
          fall_sel[g] <= wdata[EDGE_BIT];
        end
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_GRP; i++) begin
      if (addr_hit[i]) begin
        rdata[MODE_HI:MODE_LO] = mode[i];
        rdata[EDGE_BIT]        = fall_sel[i];
        rdata[FLAG_BIT]        = flags[i];
      end
    end
  end
endmodule

// File: rtl/port_irq_ctrl.sv
module port_irq_ctrl
  import port_irq_pkg::*;
#(
  parameter int unsigned NUM_GRP     = 4,
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned BASE        = 16,
  parameter int unsigned SRC_LO_LINE = 0,
  parameter int unsigned SRC_HI_LINE = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [7:0]                  bus_wdata,
  output logic [7:0]                  bus_rdata,
  input  logic [NUM_GRP*PORT_W-1:0]   port_c,
  output logic                        irq
);
  localparam int unsigned CAND_W = 2 * NUM_GRP;

  logic [CAND_W-1:0]          cand_raw;
  logic [CAND_W-1:0]          cand_sync;
  logic [NUM_GRP-1:0][1:0]    grp_mode;
  logic [NUM_GRP-1:0]         grp_fall;
  logic [NUM_GRP-1:0]         grp_clr;
  logic [NUM_GRP-1:0]         grp_flag;
  logic [NUM_GRP-1:0]         grp_hit;
  logic [NUM_GRP-1:0]         grp_live;

  genvar g;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_tap
      assign cand_raw[2*g]   = port_c[g*PORT_W + SRC_LO_LINE];
      assign cand_raw[2*g+1] = port_c[g*PORT_W + SRC_HI_LINE];
    end
  endgenerate

  pirq_sync #(.WIDTH(CAND_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cand_raw),
    .q     (cand_sync)
  );

  pirq_regs #(.NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W), .BASE(BASE)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .flags    (grp_flag),
    .mode     (grp_mode),
    .fall_sel (grp_fall),
    .clr      (grp_clr),
    .rdata    (bus_rdata)
  );

  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_grp
      pirq_group u_grp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cand     (cand_sync[2*g+1:2*g]),
        .mode     (grp_mode[g]),
        .fall_sel (grp_fall[g]),
        .clr      (grp_clr[g]),
        .flag     (grp_flag[g]),
        .hit      (grp_hit[g])
      );
      assign grp_live[g] = (grp_mode[g] == SRC_LO) || (grp_mode[g] == SRC_HI);
    end
  endgenerate

  assign irq = |(grp_flag & grp_live);
endmodule

// File: rtl/pirq_chk.sv
module pirq_chk #(
  parameter int unsigned NUM_GRP = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    irq,
  input logic [NUM_GRP-1:0]      flags,
  input logic [NUM_GRP-1:0]      hits,
  input logic [NUM_GRP-1:0]      clrs,
  input logic [NUM_GRP-1:0][1:0] modes
);
  // R1
  reset_irq_low_chk: assert property (@(posedge clk) !rst_n |=> !irq);

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|flags) |-> !irq);

  genvar g;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_chk
      // R6
      flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags[g] && !clrs[g] |=> flags[g]);

      // R6
      flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clrs[g] && !hits[g] |=> !flags[g]);

      // R7
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hits[g] |=> flags[g]);

      // R5
      off_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (modes[g] == 2'b00 || modes[g] == 2'b11) && !flags[g] |=> !flags[g]);
    end
  endgenerate
endmodule

bind port_irq_ctrl pirq_chk #(.NUM_GRP(NUM_GRP)) u_pirq_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .irq   (irq),
  .flags (grp_flag),
  .hits  (grp_hit),
  .clrs  (grp_clr),
  .modes (grp_mode)
);

// File: tb/port_irq_ctrl_bench.sv
module port_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // {grp[10:9], mode[8:7], fall[6], line[5:3], from[2], to[1], expect[0]}
  localparam logic [10:0] VEC [NV] = '{
    {2'd0, 2'b01, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1},  // R2 rising on line 0
    {2'd0, 2'b01, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0},  // R4 falling ignored
    {2'd1, 2'b01, 1'b1, 3'd0, 1'b1, 1'b0, 1'b1},  // R4 falling selected
    {2'd1, 2'b01, 1'b1, 3'd0, 1'b0, 1'b1, 1'b0},  // R4 rising ignored
    {2'd2, 2'b10, 1'b0, 3'd3, 1'b0, 1'b1, 1'b1},  // R3 line 3
    {2'd2, 2'b10, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0},  // R3 line 0 ignored
    {2'd3, 2'b10, 1'b1, 3'd3, 1'b1, 1'b0, 1'b1},  // R3 falling on line 3
    {2'd3, 2'b00, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0},  // R5 disabled
    {2'd0, 2'b11, 1'b0, 3'd3, 1'b0, 1'b1, 1'b0},  // R5 reserved
    {2'd1, 2'b01, 1'b0, 3'd5, 1'b0, 1'b1, 1'b0},  // R5 non-candidate line
    {2'd2, 2'b01, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1},  // R2 group 2
    {2'd3, 2'b01, 1'b1, 3'd3, 1'b1, 1'b0, 1'b0}   // R2 line 3 ignored in mode 01
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [31:0] port_c = '0;
  logic        irq;
  int          n_chk = 0;
  int          n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_irq_ctrl u_port_irq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .port_c    (port_c),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    for (int g = 0; g < 4; g++) begin
      rd_reg(6'(16 + g), rv);
      chk("R1 reg", rv, 8'h00);
    end

    // R9 map: stray writes ignored, unused bits read 0
    wr_reg(6'd20, 8'hFF);
    wr_reg(6'd3, 8'hFF);
    rd_reg(6'd20, rv); chk("R9 addr 20", rv, 8'h00);
    rd_reg(6'd16, rv); chk("R9 stray write", rv, 8'h00);
    wr_reg(6'd17, 8'hFF);
    rd_reg(6'd17, rv); chk("R9 fields", rv, 8'h32);
    rd_reg(6'd18, rv); chk("R9 neighbour", rv, 8'h00);
    wr_reg(6'd17, 8'h08);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [1:0] g;
      logic [1:0] md;
      logic       fl;
      logic [2:0] ln;
      logic [7:0] cfg;
      g = VEC[i][10:9]; md = VEC[i][8:7]; fl = VEC[i][6]; ln = VEC[i][5:3];
      cfg = {2'b00, md, 2'b00, fl, 1'b0};
      port_c = '0;
      for (int k = 0; k < 4; k++) wr_reg(6'(16 + k), 8'h08);
      port_c[g*8 + ln] = VEC[i][2];
      wr_reg(6'(16 + g), cfg);
      settle();
      wr_reg(6'(16 + g), cfg | 8'h08);
      settle();
      port_c[g*8 + ln] = VEC[i][1];
      settle();
      rd_reg(6'(16 + g), rv);
      chk("R2/R3/R4/R5 vector flag", {7'd0, rv[3]}, {7'd0, VEC[i][0]});
      chk("R8 vector irq", {7'd0, irq}, {7'd0, VEC[i][0]});
    end

    // R2 latency and R6 write-one-to-clear
    port_c = '0;
    for (int k = 0; k < 4; k++) wr_reg(6'(16 + k), 8'h08);
    wr_reg(6'd16, 8'h10);
    settle();
    port_c[0] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2 not yet", {7'd0, irq}, 8'h00);
    @(posedge clk);
    @(negedge clk);
    chk("R2 set at k+2", {7'd0, irq}, 8'h01);
    wr_reg(6'd16, 8'h10);
    rd_reg(6'd16, rv); chk("R6 write 0 keeps", rv, 8'h18);
    wr_reg(6'd16, 8'h18);
    rd_reg(6'd16, rv); chk("R6 clear", rv, 8'h10);
    chk("R6 irq low", {7'd0, irq}, 8'h00);

    // R8 masking by mode
    port_c[0] = 1'b0;
    settle();
    port_c[0] = 1'b1;
    settle();
    wr_reg(6'd16, 8'h00);
    chk("R8 masked irq", {7'd0, irq}, 8'h00);
    rd_reg(6'd16, rv); chk("R8 flag kept", rv, 8'h08);
    wr_reg(6'd16, 8'h10);
    chk("R8 unmasked irq", {7'd0, irq}, 8'h01);
    wr_reg(6'd16, 8'h18);

    // R7 edge and clear in the same cycle
    port_c[0] = 1'b0;
    settle();
    port_c[0] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'd16; bus_wdata = 8'h18;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    rd_reg(6'd16, rv); chk("R7 set wins", rv, 8'h18);
    wr_reg(6'd16, 8'h08);

    // R10 two groups at once
    port_c = '0;
    wr_reg(6'd17, 8'h18);
    wr_reg(6'd18, 8'h18);
    settle();
    port_c[8] = 1'b1;
    port_c[16] = 1'b1;
    settle();
    rd_reg(6'd17, rv); chk("R10 group 1", rv, 8'h18);
    rd_reg(6'd18, rv); chk("R10 group 2", rv, 8'h18);
    wr_reg(6'd17, 8'h18);
    chk("R10 irq still", {7'd0, irq}, 8'h01);
    rd_reg(6'd18, rv); chk("R10 other kept", rv, 8'h18);
    wr_reg(6'd18, 8'h18);
    chk("R10 irq clear", {7'd0, irq}, 8'h00);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule